// File: doc/BRIEF.md
# Programmable Baud Rate Divider

This block divides a reference clock by a 16-bit programmable divisor. Its output is the 16x clock that a serial port uses to time bit sampling and bit shifting. Software writes the divisor one byte at a time, through a write-strobe vector and a shared data byte. A write to either byte restarts the division immediately. Software therefore never has to wait out a long count left over from an earlier divisor.

For a divisor of three or more, each output period lasts that many reference clocks. The output is low for the first two clocks of the period and high for the rest. Three divisor values have their own output forms:
- A divisor of 2 gives a square wave at half the reference rate.
- A divisor of 1 passes the inverted reference clock to the output.
- A divisor of 0 behaves as a division by three.

Alongside the waveform, the block raises a single-cycle enable in the first high cycle of every period. A synchronous transmitter or receiver can use this enable instead of the derived clock.

Top module: `baud_div`

## Requirements
- R1: While rst_ni is low, the divisor is cleared to 0, baud_o is held high and tick_o is low.
- R2: wr_be_i[0] writes wr_data_i into divisor bits 7:0, and wr_be_i[1] writes it into bits 15:8. The divisor is the unsigned 16-bit value of the two bytes.
- R3: Any write restarts the period. The cycle after the write edge is the first cycle of a new period using the new divisor, so baud_o is low there unless the new divisor is 1.
- R4: A divisor of 0 gives a period of 3 clocks: low for 2 clocks, then high for 1.
- R5: A divisor of 1 drives baud_o with the inverse of clk_i and holds tick_o high in every cycle.
- R6: A divisor of 2 gives a period of 2 clocks: low for 1 clock, then high for 1.
- R7: A divisor N of 3 or more gives a period of N clocks: low for 2 clocks, then high for N-2.
- R8: Consecutive periods follow each other with no idle cycle, so ticks are exactly one period apart while no write occurs.
- R9: tick_o is high for exactly the first high cycle of each period, which is the cycle in which baud_o rises.
- R10: After reset with no write, the first cycle is high with no tick. The block then runs with divisor 0, following R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_be_i | input | 2 | Per-byte write strobes (bit 0 low byte, bit 1 high byte) |
| wr_data_i | input | 8 | Byte written to the selected divisor byte(s) |
| baud_o | output | 1 | Divided 16x baud clock |
| tick_o | output | 1 | One-cycle enable in the first high cycle of each period |

## Verification
Directed runs visit divisors 0, 1, 2, 3 and one value above 255. They show the special forms apart from the general low-two/high-rest shape, and the byte order apart from a swapped one. Random divisors, mostly small, are written with random strobes at random points in the period. Writes landing mid-period show an immediate reload apart from one deferred to terminal count. Long undisturbed stretches measure the spacing between ticks, which exposes an extra or missing cycle at the wrap. A reset applied mid-run shows that the output returns high and the divisor returns to 0.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;
  localparam int unsigned DIV_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NB     = DIV_W / BYTE_W;

  typedef enum logic [1:0] {
    MODE_PASS,
    MODE_HALF,
    MODE_SHAPED
  } wave_mode_e;

  // divisor 0 runs as divide-by-3
  function automatic logic [DIV_W-1:0] period_of(input logic [DIV_W-1:0] div);
    return (div == '0) ? DIV_W'(3) : div;
  endfunction

  function automatic wave_mode_e mode_of(input logic [DIV_W-1:0] per);
    if (per == DIV_W'(1))      return MODE_PASS;
    else if (per == DIV_W'(2)) return MODE_HALF;
    else                       return MODE_SHAPED;
  endfunction
endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned NB    = DIV_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NB-1:0]     wr_be_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [DIV_W-1:0]  div_q_o,
  output logic [DIV_W-1:0]  div_d_o,
  output logic              load_o
);
  logic [DIV_W-1:0] div_q;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign div_d_o[b*BYTE_W +: BYTE_W] =
      wr_be_i[b] ? wr_data_i : div_q[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d_o;
  end

  assign div_q_o = div_q;
  assign load_o  = |wr_be_i;

  p_byte_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_be_i[0] |=> div_q[BYTE_W-1:0] == $past(wr_data_i));
  p_byte_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |=> $stable(div_q));
endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] period_i,
  input  logic [DIV_W-1:0] period_next_i,
  output logic [DIV_W-1:0] cnt_o
);
  logic [DIV_W-1:0] cnt_q;

  // counts period..1; 0 only after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= period_next_i;
    else if (cnt_q <= DIV_W'(1))   cnt_q <= period_i;
    else                           cnt_q <= cnt_q - DIV_W'(1);
  end

  assign cnt_o = cnt_q;

  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= period_i);
  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == DIV_W'(1)) |=> cnt_q == $past(period_i));
  p_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(period_next_i));
endmodule

// File: rtl/baud_div_wave.sv
module baud_div_wave
  import baud_div_pkg::*;
#(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned LOW_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] period_i,
  input  logic [DIV_W-1:0] cnt_i,
  output logic             baud_o,
  output logic             tick_o
);
  wave_mode_e       mode;
  logic [DIV_W-1:0] low_len;
  logic [DIV_W-1:0] rise_cnt;
  logic             live;
  logic             low;

  assign mode = mode_of(period_i);
  assign live = (cnt_i != '0);

  always_comb begin
    unique case (mode)
      MODE_PASS: low_len = '0;
      MODE_HALF: low_len = DIV_W'(1);
      default:   low_len = DIV_W'(LOW_CYC);
    endcase
  end

  assign rise_cnt = period_i - low_len;
  assign low      = live && (cnt_i > rise_cnt);

  always_comb begin
    if (!rst_ni)                baud_o = 1'b1;
    else if (mode == MODE_PASS) baud_o = ~clk_i;
    else                        baud_o = ~low;
  end

  assign tick_o = rst_ni && live && ((mode == MODE_PASS) || (cnt_i == rise_cnt));

  p_tick_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && mode != MODE_PASS) |-> (!low && $past(low)));
  p_low_two_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(low) && mode == MODE_SHAPED && !load_i) |=> low);
  p_half_alt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_HALF && !load_i && low) |=> !low);
endmodule

// File: rtl/baud_div.sv
module baud_div
  import baud_div_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NB-1:0]     wr_be_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic              baud_o,
  output logic              tick_o
);
  logic [DIV_W-1:0] div_q, div_d, cnt;
  logic [DIV_W-1:0] period, period_next;
  logic             load;

  baud_div_latch #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_be_i   (wr_be_i),
    .wr_data_i (wr_data_i),
    .div_q_o   (div_q),
    .div_d_o   (div_d),
    .load_o    (load)
  );

  assign period      = period_of(div_q);
  assign period_next = period_of(div_d);

  baud_div_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (load),
    .period_i      (period),
    .period_next_i (period_next),
    .cnt_o         (cnt)
  );

  baud_div_wave #(.DIV_W(DIV_W), .LOW_CYC(2)) u_wave (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .period_i (period),
    .cnt_i    (cnt),
    .baud_o   (baud_o),
    .tick_o   (tick_o)
  );

  always_comb begin
    if (!rst_ni) begin
      a_rst_high_r1: assert (baud_o && !tick_o);
    end
  end

  p_write_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && period_next != DIV_W'(1)) |=> !baud_o);
  p_tick_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && period >= DIV_W'(2) && !load) |=> !tick_o);
endmodule

// File: tb/baud_div_tb.sv
module baud_div_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] wr_be = '0;
  logic [7:0] wr_data = '0;
  logic       baud, tick;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference model
  int unsigned m_div = 0;
  int unsigned m_ph = 0;
  bit          m_started = 0;
  bit          m_just_wr = 0;
  int unsigned iv = 0;
  bit          iv_ok = 0;

  baud_div u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_be_i   (wr_be),
    .wr_data_i (wr_data),
    .baud_o    (baud),
    .tick_o    (tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int unsigned per_f(int unsigned d);
    return (d == 0) ? 3 : d;
  endfunction

  function automatic int unsigned low_f(int unsigned p);
    return (p == 1) ? 0 : (p == 2) ? 1 : 2;
  endfunction

  function automatic string tag_f(int unsigned d);
    if (d == 0) return "R4";
    if (d == 1) return "R5";
    if (d == 2) return "R6";
    if (d > 255) return "R2/R7";
    return "R7";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_ph = 0; m_started = 0; m_just_wr = 0; iv_ok = 0;
    end else if (wr_be != 0) begin
      if (wr_be[0]) m_div = (m_div & 32'hff00) | wr_data;
      if (wr_be[1]) m_div = (m_div & 32'h00ff) | (32'(wr_data) << 8);
      m_ph = 0; m_started = 1; m_just_wr = 1; iv_ok = 0;
    end else if (!m_started) begin
      m_started = 1; m_ph = 0; m_just_wr = 0;
    end else begin
      m_ph = (m_ph + 1) % per_f(m_div); m_just_wr = 0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected < %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (div=%0d ph=%0d t=%0t)",
               tag, act, exp, m_div, m_ph, $time);
    end
  endtask

  // called at negedge, away from the active edge
  task automatic check_now();
    int unsigned p;
    bit eb, et;
    p = per_f(m_div);
    if (!rst_n) begin
      chk(baud == 1'b1, "R1 baud", baud, 1);
      chk(tick == 1'b0, "R1 tick", tick, 0);
      return;
    end
    if (!m_started) begin
      eb = 1; et = 0;
      chk(baud == eb, "R10 baud", baud, eb);
      chk(tick == et, "R10 tick", tick, et);
      return;
    end
    eb = (m_ph >= low_f(p));
    et = (m_ph == low_f(p));
    if (m_just_wr && p != 1) chk(baud == 1'b0, "R3 restart low", baud, 0);
    chk(baud == eb, {tag_f(m_div), " baud"}, baud, eb);
    chk(tick == et, "R9 tick", tick, et);
    iv++;
    if (tick) begin
      if (iv_ok && p >= 2) chk(iv == p, "R8 tick spacing", iv, p);
      iv_ok = 1; iv = 0;
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now();
      wr_be = '0;
    end
  endtask

  task automatic wr(input logic [1:0] be, input logic [7:0] d);
    @(negedge clk);
    check_now();
    wr_be = be; wr_data = d;
  endtask

  task automatic set_div(input int unsigned d);
    wr(2'b11, 8'h00);
    wr_be = 2'b10; wr_data = d[15:8];
    wr(2'b01, d[7:0]);
  endtask

  initial begin
    void'($urandom(32'd4242));
    step(3);                 // R1 during reset
    @(negedge clk); rst_n = 1'b1;
    step(20);                // R10 then divisor 0 (R4)
    set_div(1); step(6);
    repeat (4) begin         // R5 mid-high phase of clk: baud is low
      @(posedge clk); #1;
      chk(baud == 1'b0, "R5 inverse clk", baud, 0);
      chk(tick == 1'b1, "R5 tick", tick, 1);
    end
    set_div(2); step(10);
    set_div(3); step(12);
    set_div(5); step(17);
    set_div(0); step(12);
    set_div(300); step(700); // R2 high byte
    // R3 rewrite of same value mid-period restarts
    step(3); wr(2'b01, 8'd44); step(5); wr(2'b10, 8'd1); step(5);
    set_div(9); step(4);
    wr(2'b01, 8'd9); step(30);
    for (int i = 0; i < 1500; i++) begin
      int unsigned r;
      r = $urandom % 16;
      if (r == 0) begin
        logic [1:0] be;
        be = 2'($urandom % 3 + 1);
        wr(be, be[1] ? (($urandom % 20 == 0) ? 8'd1 : 8'd0) : 8'($urandom % 24));
        step(1);
      end else begin
        step(1 + $urandom % 20);
      end
    end
    // R1 mid-run reset
    set_div(7); step(4);
    @(negedge clk); rst_n = 1'b0;
    step(3);
    @(negedge clk); rst_n = 1'b1;
    step(12);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule